// File: doc/BRIEF.md
# Delay-Slot Next-PC and Branch Resolution Unit

This unit decides where instruction fetch goes next in a core that always executes the instruction after a control transfer. Each cycle it looks at one instruction: the PC of that instruction, its flow code, two register operands, a 16-bit branch displacement, a 26-bit absolute jump field, a register jump target and a link destination index. From these it produces the next fetch address, a flag that the transfer was taken, and a link-register write request with its index and value.

A taken transfer does not redirect fetch at once. The unit first sends fetch to the sequential address, which is the delay slot. It keeps the resolved target in a one-entry redirect register, and the next valid instruction, the slot, hands fetch that target. The slot instruction's own transfer and link request are ignored. Register index 0 is a hard zero, so a link aimed at it is dropped. Cycles with `instrValid` low are bubbles: they do not move the PC and they keep any pending redirect.

Top module: `nextpc_unit`

## Requirements
- R1: After reset no redirect is pending: the first valid instruction with flow code 0 (sequential) gives `nextPc` = `curPc`+4 with `taken` low, even if a taken transfer was resolved just before reset.
- R2: While `instrValid` is low, `nextPc` equals `curPc`, `taken` and `linkWe` are low, and a pending redirect is kept for the next valid instruction.
- R3: Code 1 is taken when the two operands are equal and code 2 when they differ. A taken transfer drives `taken` high and `nextPc` = `curPc`+4 in that cycle. Its target is `curPc`+4 plus the sign-extended displacement shifted left by 2. An untaken one gives `curPc`+4 and arms nothing.
- R4: Codes 3, 4, 5 and 6 compare the first operand, as a signed value, against zero with ≤, >, < and ≥ respectively.
- R5: Codes 7 (<0) and 8 (≥0) branch like codes 5 and 6. Whether or not they are taken, they request a link write to register 31 with the value `curPc`+8.
- R6: Code 9 jumps to {upper 4 bits of `curPc`+4, `jumpIdx`, 2'b00}. Code 10 does the same and also links `curPc`+8 into register 31.
- R7: Code 11 jumps to `regTarget`. Code 12 does the same and links `curPc`+8 into register `linkDest`. When `linkDest` is 0, `linkWe` stays low.
- R8: The valid instruction that follows a taken transfer gets `nextPc` equal to the held target. Its own flow code then has no effect: `taken` and `linkWe` stay low.
- R9: The redirect is used once. The instruction after the delay slot proceeds sequentially.
- R10: A displacement with bit 15 set is sign-extended, so the branch target lies below the delay slot.
- R11: Flow codes 13 to 15 behave as sequential: `taken` and `linkWe` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrValid | input | 1 | An instruction is presented this cycle |
| opCode | input | 4 | Flow code (see requirements) |
| curPc | input | 32 | PC of the presented instruction |
| rsVal | input | 32 | First register operand |
| rtVal | input | 32 | Second register operand |
| branchOff | input | 16 | Branch displacement in words |
| jumpIdx | input | 26 | Absolute jump word index |
| regTarget | input | 32 | Register-held jump target |
| linkDest | input | 5 | Link destination for register jump-and-link |
| nextPc | output | 32 | Next fetch address |
| taken | output | 1 | Presented transfer is taken |
| linkWe | output | 1 | Link register write enable |
| linkAddr | output | 5 | Link register index |
| linkData | output | 32 | Return address to write |

## Verification
`nextPc`, `taken` and the link outputs follow the presented instruction within the same cycle. A taken target shows up on `nextPc` at the next valid instruction, one or more clocks later. The driver predicts each cycle's results with its own model of the redirect register and queues them. The monitor checks them a fixed interval after the inputs change, before the next rising edge. This means every comparison sees same-cycle outputs, while the effect of a redirect is checked on the following valid instruction. Bubble cycles and a reset placed between a branch and its slot check that the redirect is held or cleared in the right clock.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;

  typedef enum logic [3:0] {
    FLOW_SEQ           = 4'd0,
    FLOW_EQ            = 4'd1,
    FLOW_NE            = 4'd2,
    FLOW_LEZ           = 4'd3,
    FLOW_GTZ           = 4'd4,
    FLOW_LTZ           = 4'd5,
    FLOW_GEZ           = 4'd6,
    FLOW_LTZ_LINK      = 4'd7,
    FLOW_GEZ_LINK      = 4'd8,
    FLOW_JUMP          = 4'd9,
    FLOW_JUMP_LINK     = 4'd10,
    FLOW_JUMP_REG      = 4'd11,
    FLOW_JUMP_REG_LINK = 4'd12
  } flowOp_e;

  typedef enum logic [1:0] {
    TGT_BRANCH = 2'd0,
    TGT_ABS    = 2'd1,
    TGT_REG    = 2'd2
  } tgtSel_e;

  // control -> datapath
  typedef struct packed {
    logic    transfer;
    tgtSel_e tgtSel;
    logic    linkEn;
    logic    useDest;
  } flowStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic opEq;
    logic rsNeg;
    logic rsZero;
  } cmpFlags_t;

endpackage

// File: rtl/nextpc_ctrl.sv
module nextpc_ctrl
  import nextpc_pkg::*;
(
  input  logic        instrValid,
  input  logic [3:0]  opCode,
  input  cmpFlags_t   flags,
  input  logic        slotPending,
  output flowStrobe_t strobe
);

  logic condMet;
  logic isLink;
  logic isFlow;

  always_comb begin
    condMet = 1'b0;
    isLink  = 1'b0;
    isFlow  = 1'b1;
    strobe  = '0;
    strobe.tgtSel = TGT_BRANCH;
    case (flowOp_e'(opCode))
      FLOW_EQ:        condMet = flags.opEq;
      FLOW_NE:        condMet = !flags.opEq;
      FLOW_LEZ:       condMet = flags.rsNeg || flags.rsZero;
      FLOW_GTZ:       condMet = !flags.rsNeg && !flags.rsZero;
      FLOW_LTZ:       condMet = flags.rsNeg;
      FLOW_GEZ:       condMet = !flags.rsNeg;
      FLOW_LTZ_LINK: begin
        condMet = flags.rsNeg;
        isLink  = 1'b1;
      end
      FLOW_GEZ_LINK: begin
        condMet = !flags.rsNeg;
        isLink  = 1'b1;
      end
      FLOW_JUMP: begin
        condMet = 1'b1;
        strobe.tgtSel = TGT_ABS;
      end
      FLOW_JUMP_LINK: begin
        condMet = 1'b1;
        isLink  = 1'b1;
        strobe.tgtSel = TGT_ABS;
      end
      FLOW_JUMP_REG: begin
        condMet = 1'b1;
        strobe.tgtSel = TGT_REG;
      end
      FLOW_JUMP_REG_LINK: begin
        condMet = 1'b1;
        isLink  = 1'b1;
        strobe.tgtSel = TGT_REG;
        strobe.useDest = 1'b1;
      end
      default: isFlow = 1'b0;
    endcase
    // a delay-slot instruction cannot start a new transfer
    if (!instrValid || slotPending || !isFlow) begin
      condMet = 1'b0;
      isLink  = 1'b0;
    end
    strobe.transfer = condMet;
    strobe.linkEn   = isLink;
  end

endmodule

// File: rtl/nextpc_path.sv
module nextpc_path
  import nextpc_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int OFF_W    = 16,
  parameter int IDX_W    = 26,
  parameter int REG_AW   = 5,
  parameter int LINK_REG = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrValid,
  input  logic [XLEN-1:0]   curPc,
  input  logic [XLEN-1:0]   rsVal,
  input  logic [XLEN-1:0]   rtVal,
  input  logic [OFF_W-1:0]  branchOff,
  input  logic [IDX_W-1:0]  jumpIdx,
  input  logic [XLEN-1:0]   regTarget,
  input  logic [REG_AW-1:0] linkDest,
  input  flowStrobe_t       strobe,
  output cmpFlags_t         flags,
  output logic              slotPending,
  output logic [XLEN-1:0]   nextPc,
  output logic              linkWe,
  output logic [REG_AW-1:0] linkAddr,
  output logic [XLEN-1:0]   linkData
);

  localparam int EXT_W   = XLEN - OFF_W - 2;
  localparam int HI_W    = XLEN - IDX_W - 2;
  localparam int INSTR_B = 4;

  logic [XLEN-1:0] seqPc;
  logic [XLEN-1:0] offExt;
  logic [XLEN-1:0] branchTgt;
  logic [XLEN-1:0] absTgt;
  logic [XLEN-1:0] resolvedTgt;
  logic [XLEN-1:0] pendTgt;

  assign flags.opEq   = (rsVal == rtVal);
  assign flags.rsNeg  = rsVal[XLEN-1];
  assign flags.rsZero = (rsVal == '0);

  assign seqPc     = curPc + XLEN'(INSTR_B);
  assign offExt    = {{EXT_W{branchOff[OFF_W-1]}}, branchOff, 2'b00};
  assign branchTgt = seqPc + offExt;
  assign absTgt    = {seqPc[XLEN-1 -: HI_W], jumpIdx, 2'b00};

  always_comb begin
    case (strobe.tgtSel)
      TGT_ABS: resolvedTgt = absTgt;
      TGT_REG: resolvedTgt = regTarget;
      default: resolvedTgt = branchTgt;
    endcase
  end

  // one-entry redirect register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotPending <= 1'b0;
      pendTgt     <= '0;
    end else if (instrValid) begin
      if (slotPending) begin
        slotPending <= 1'b0;
      end else if (strobe.transfer) begin
        slotPending <= 1'b1;
        pendTgt     <= resolvedTgt;
      end
    end
  end

  always_comb begin
    if (!instrValid)      nextPc = curPc;
    else if (slotPending) nextPc = pendTgt;
    else                  nextPc = seqPc;
  end

  assign linkAddr = strobe.useDest ? linkDest : REG_AW'(LINK_REG);
  assign linkWe   = strobe.linkEn && (linkAddr != '0);
  assign linkData = curPc + XLEN'(2 * INSTR_B);

  assert_redirect_armed_R3: assert property (@(posedge clk) disable iff (!rstN)
    instrValid && strobe.transfer |=> slotPending);

  assert_taken_to_slot_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.transfer |-> nextPc == curPc + XLEN'(INSTR_B));

  assert_bubble_holds_R2: assert property (@(posedge clk) disable iff (!rstN)
    slotPending && !instrValid |=> slotPending && $stable(pendTgt));

  assert_bubble_pc_R2: assert property (@(posedge clk) disable iff (!rstN)
    !instrValid |-> nextPc == curPc && !linkWe);

  assert_slot_consumed_R9: assert property (@(posedge clk) disable iff (!rstN)
    slotPending && instrValid |=> !slotPending);

endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
  import nextpc_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int OFF_W    = 16,
  parameter int IDX_W    = 26,
  parameter int REG_AW   = 5,
  parameter int LINK_REG = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrValid,
  input  logic [3:0]        opCode,
  input  logic [XLEN-1:0]   curPc,
  input  logic [XLEN-1:0]   rsVal,
  input  logic [XLEN-1:0]   rtVal,
  input  logic [OFF_W-1:0]  branchOff,
  input  logic [IDX_W-1:0]  jumpIdx,
  input  logic [XLEN-1:0]   regTarget,
  input  logic [REG_AW-1:0] linkDest,
  output logic [XLEN-1:0]   nextPc,
  output logic              taken,
  output logic              linkWe,
  output logic [REG_AW-1:0] linkAddr,
  output logic [XLEN-1:0]   linkData
);

  flowStrobe_t strobe;
  cmpFlags_t   flags;
  logic        slotPending;

  nextpc_ctrl u_ctrl (
    .instrValid  (instrValid),
    .opCode      (opCode),
    .flags       (flags),
    .slotPending (slotPending),
    .strobe      (strobe)
  );

  nextpc_path #(
    .XLEN     (XLEN),
    .OFF_W    (OFF_W),
    .IDX_W    (IDX_W),
    .REG_AW   (REG_AW),
    .LINK_REG (LINK_REG)
  ) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .instrValid  (instrValid),
    .curPc       (curPc),
    .rsVal       (rsVal),
    .rtVal       (rtVal),
    .branchOff   (branchOff),
    .jumpIdx     (jumpIdx),
    .regTarget   (regTarget),
    .linkDest    (linkDest),
    .strobe      (strobe),
    .flags       (flags),
    .slotPending (slotPending),
    .nextPc      (nextPc),
    .linkWe      (linkWe),
    .linkAddr    (linkAddr),
    .linkData    (linkData)
  );

  assign taken = strobe.transfer;

  assert_cond_link_R5: assert property (@(posedge clk) disable iff (!rstN)
    instrValid && !slotPending && (opCode == 4'd7 || opCode == 4'd8)
      |-> linkWe && linkAddr == REG_AW'(LINK_REG));

  assert_slot_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    slotPending |-> !taken && !linkWe);

  assert_spare_codes_R11: assert property (@(posedge clk) disable iff (!rstN)
    opCode > 4'd12 |-> !taken && !linkWe);

endmodule

// File: tb/test_nextpc_unit.sv
module test_nextpc_unit;

  localparam time HALF = 4ns;

  logic        clk = 1'b0;
  logic        rstN;
  logic        instrValid;
  logic [3:0]  opCode;
  logic [31:0] curPc, rsVal, rtVal, regTarget;
  logic [15:0] branchOff;
  logic [25:0] jumpIdx;
  logic [4:0]  linkDest;
  logic [31:0] nextPc, linkData;
  logic        taken, linkWe;
  logic [4:0]  linkAddr;

  nextpc_unit i_nextpc_unit (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .opCode(opCode),
    .curPc(curPc), .rsVal(rsVal), .rtVal(rtVal), .branchOff(branchOff),
    .jumpIdx(jumpIdx), .regTarget(regTarget), .linkDest(linkDest),
    .nextPc(nextPc), .taken(taken), .linkWe(linkWe),
    .linkAddr(linkAddr), .linkData(linkData)
  );

  always #HALF clk = ~clk;

  typedef struct {
    int          req;
    logic [31:0] expPc;
    logic        expTaken;
    logic        expWe;
    logic [4:0]  expAddr;
    logic [31:0] expData;
  } expItem_t;

  expItem_t    sb[$];
  int          errors = 0;
  int          checks = 0;
  logic        mPend  = 1'b0;
  logic [31:0] mTgt   = '0;
  bit          finished = 1'b0;

  // monitor: compare well after the inputs settle, before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #2ns;
      while (sb.size() > 0) begin
        expItem_t it;
        it = sb.pop_front();
        checks++;
        if (nextPc !== it.expPc || taken !== it.expTaken || linkWe !== it.expWe ||
            (it.expWe && (linkAddr !== it.expAddr || linkData !== it.expData))) begin
          errors++;
          $display("FAIL R%0d: nextPc=%h taken=%b we=%b addr=%0d data=%h expected nextPc=%h taken=%b we=%b addr=%0d data=%h",
                   it.req, nextPc, taken, linkWe, linkAddr, linkData,
                   it.expPc, it.expTaken, it.expWe, it.expAddr, it.expData);
        end
      end
    end
  end

  task automatic issue(input int req, input logic [3:0] op, input logic [31:0] pc,
                       input logic [31:0] rs, input logic [31:0] rt,
                       input logic [15:0] off, input logic [25:0] idx,
                       input logic [31:0] rtg, input logic [4:0] dst);
    expItem_t    it;
    logic [31:0] seq, tgt;
    logic        tk, lk;
    logic [4:0]  lad;
    seq = pc + 32'd4;
    tk = 1'b0; lk = 1'b0; lad = 5'd31;
    tgt = seq + {{14{off[15]}}, off, 2'b00};
    it.req = req;
    it.expData = pc + 32'd8;
    if (mPend) begin
      it.expPc = mTgt;
      mPend = 1'b0;
    end else begin
      case (op)
        4'd1: tk = (rs == rt);
        4'd2: tk = (rs != rt);
        4'd3: tk = ($signed(rs) <= 0);
        4'd4: tk = ($signed(rs) > 0);
        4'd5: tk = ($signed(rs) < 0);
        4'd6: tk = ($signed(rs) >= 0);
        4'd7: begin tk = ($signed(rs) < 0);  lk = 1'b1; end
        4'd8: begin tk = ($signed(rs) >= 0); lk = 1'b1; end
        4'd9: begin tk = 1'b1; tgt = {seq[31:28], idx, 2'b00}; end
        4'd10: begin tk = 1'b1; lk = 1'b1; tgt = {seq[31:28], idx, 2'b00}; end
        4'd11: begin tk = 1'b1; tgt = rtg; end
        4'd12: begin tk = 1'b1; lk = 1'b1; tgt = rtg; lad = dst; end
        default: ;
      endcase
      it.expPc = seq;
      if (tk) begin
        mPend = 1'b1;
        mTgt  = tgt;
      end
    end
    it.expTaken = tk;
    it.expWe    = lk && (lad != 5'd0);
    it.expAddr  = lad;
    @(negedge clk);
    instrValid = 1'b1; opCode = op; curPc = pc; rsVal = rs; rtVal = rt;
    branchOff = off; jumpIdx = idx; regTarget = rtg; linkDest = dst;
    sb.push_back(it);
  endtask

  task automatic bubble(input int req, input logic [31:0] pc);
    expItem_t it;
    it.req = req; it.expPc = pc; it.expTaken = 1'b0; it.expWe = 1'b0;
    it.expAddr = '0; it.expData = '0;
    @(negedge clk);
    instrValid = 1'b0; opCode = 4'd10; curPc = pc;
    sb.push_back(it);
  endtask

  task automatic seqAt(input int req, input logic [31:0] pc);
    issue(req, 4'd0, pc, 32'd0, 32'd0, 16'd0, 26'd0, 32'd0, 5'd0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; instrValid = 1'b0;
    mPend = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    rstN = 1'b0; instrValid = 1'b0; opCode = '0; curPc = '0; rsVal = '0;
    rtVal = '0; branchOff = '0; jumpIdx = '0; regTarget = '0; linkDest = '0;
    doReset();

    // R1 reset state
    seqAt(1, 32'h0000_0100);

    // R3 equal taken, R8 slot redirect, R9 one-shot
    issue(3, 4'd1, 32'h200, 32'd5, 32'd5, 16'h0010, 26'd0, 32'd0, 5'd0);
    seqAt(8, 32'h204);
    seqAt(9, 32'h244);
    // R3 equal not taken, then sequential
    issue(3, 4'd1, 32'h300, 32'd5, 32'd6, 16'h0010, 26'd0, 32'd0, 5'd0);
    seqAt(3, 32'h304);
    // R3 not-equal both ways
    issue(3, 4'd2, 32'h400, 32'd1, 32'd2, 16'h0004, 26'd0, 32'd0, 5'd0);
    seqAt(8, 32'h404);
    issue(3, 4'd2, 32'h500, 32'd7, 32'd7, 16'h0004, 26'd0, 32'd0, 5'd0);
    seqAt(3, 32'h504);

    // R4 signed zero compares
    begin
      logic [31:0] vals [3] = '{32'd0, 32'd1, 32'h8000_0000};
      for (int op = 3; op <= 6; op++) begin
        for (int v = 0; v < 3; v++) begin
          issue(4, 4'(op), 32'h1000 + 32'(op * 64 + v * 16), vals[v], 32'd0,
                16'h0020, 26'd0, 32'd0, 5'd0);
          seqAt(4, 32'h1004 + 32'(op * 64 + v * 16));
        end
      end
    end

    // R5 conditional links, taken and untaken
    issue(5, 4'd7, 32'h2000, 32'hFFFF_FFFF, 32'd0, 16'h0008, 26'd0, 32'd0, 5'd0);
    seqAt(5, 32'h2004);
    issue(5, 4'd7, 32'h2100, 32'd3, 32'd0, 16'h0008, 26'd0, 32'd0, 5'd0);
    seqAt(5, 32'h2104);
    issue(5, 4'd8, 32'h2200, 32'd0, 32'd0, 16'h0008, 26'd0, 32'd0, 5'd0);
    seqAt(5, 32'h2204);
    issue(5, 4'd8, 32'h2300, 32'h8000_0001, 32'd0, 16'h0008, 26'd0, 32'd0, 5'd0);
    seqAt(5, 32'h2304);

    // R10 negative displacement
    issue(10, 4'd1, 32'h3000, 32'd0, 32'd0, 16'hFFFF, 26'd0, 32'd0, 5'd0);
    seqAt(10, 32'h3004);
    issue(10, 4'd2, 32'h3100, 32'd0, 32'd1, 16'h8000, 26'd0, 32'd0, 5'd0);
    seqAt(10, 32'h3104);

    // R6 absolute jumps, incl. slot crossing a 4-bit region boundary
    issue(6, 4'd9, 32'hA000_0010, 32'd0, 32'd0, 16'd0, 26'h123_4567, 32'd0, 5'd0);
    seqAt(6, 32'hA000_0014);
    issue(6, 4'd10, 32'hAFFF_FFFC, 32'd0, 32'd0, 16'd0, 26'h000_0040, 32'd0, 5'd0);
    seqAt(6, 32'hB000_0000);

    // R7 register jumps, link to chosen register, register 0 dropped
    issue(7, 4'd11, 32'h5000, 32'd0, 32'd0, 16'd0, 26'd0, 32'h0000_4000, 5'd0);
    seqAt(7, 32'h5004);
    issue(7, 4'd12, 32'h5100, 32'd0, 32'd0, 16'd0, 26'd0, 32'h0000_7000, 5'd9);
    seqAt(7, 32'h5104);
    issue(7, 4'd12, 32'h5200, 32'd0, 32'd0, 16'd0, 26'd0, 32'h0000_7100, 5'd0);
    seqAt(7, 32'h5204);

    // R8 transfer in the slot ignored (branch and linking jump)
    issue(8, 4'd1, 32'h6000, 32'd1, 32'd1, 16'h0010, 26'd0, 32'd0, 5'd0);
    issue(8, 4'd10, 32'h6004, 32'd0, 32'd0, 16'd0, 26'h000_0100, 32'd0, 5'd0);
    seqAt(9, 32'h6044);

    // R2 bubbles between branch and slot keep the redirect
    issue(2, 4'd9, 32'h7000, 32'd0, 32'd0, 16'd0, 26'h000_0200, 32'd0, 5'd0);
    bubble(2, 32'h7004);
    bubble(2, 32'h7004);
    seqAt(2, 32'h7004);
    seqAt(9, 32'h0000_0800);

    // R11 spare codes act sequential
    issue(11, 4'd13, 32'h8000, 32'd0, 32'd0, 16'h0010, 26'd0, 32'd0, 5'd0);
    issue(11, 4'd15, 32'h8004, 32'hFFFF_FFFF, 32'd0, 16'h0010, 26'd0, 32'd0, 5'd0);
    seqAt(11, 32'h8008);

    // R1 reset clears a pending redirect
    issue(1, 4'd11, 32'h9000, 32'd0, 32'd0, 16'd0, 26'd0, 32'h0000_ABC0, 5'd0);
    doReset();
    seqAt(1, 32'h9004);

    @(negedge clk);
    instrValid = 1'b0;
    #3ns;
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8ns * 20000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule